// File: doc/BRIEF.md
# Oscillator DAC Calibration Sequencer

This block centres the control DAC of a data-separator oscillator, one recording zone at a time, with no processor in the loop. When started, it loads each zone's rate numerator and denominator into the channel's register file and writes a nominal DAC code. It then waits a programmable settling time and reads a comparator flag that reports whether the oscillator control voltage is above its midpoint. A high flag moves the DAC code down by one and a low flag moves it up by one. The search for a zone ends on the first sample whose flag differs from the one before it. The code in the DAC at that moment becomes the zone's calibrated setting.

If the code reaches zero or full scale while the flag still calls for a further step in that direction, the zone is closed with an error mark and the last code is kept. The sequencer works through every zone in ascending order and then pulses `done`. The per-zone results stay in a small table that can be read at any time through a zone index, so later reads of a zone can reuse the stored code.

Top module: `osc_cal_seq`

## Requirements
- R1: A run loads each zone with two writes on consecutive cycles: first address 0x0E carrying the zone's numerator (bits [RATEW*z +: RATEW] of `num_tbl`), then address 0x06 carrying the zone's denominator (the same slice of `den_tbl`).
- R2: The cycle after the denominator write, the block writes `nominal` to address 0x04, the DAC register.
- R3: After every write to 0x04 the block waits `settle_len`+1 cycles with `wr_en` low. It samples `cmp_above` in the last of those cycles.
- R4: If a sample does not end the zone, the next cycle writes 0x04 with the previous code minus one when `cmp_above` was 1, or plus one when it was 0.
- R5: When a sample differs from the previous sample of the same zone, the current DAC code is stored as that zone's calibrated value with its error bit cleared. The first sample of a zone never counts as a reversal.
- R6: When the sample calls for a step below code 0 or above the all-ones code, that code is stored with the zone's error bit set, and the zone ends.
- R7: Zones run from 0 to NZONES-1. One cycle with `busy` high and no write separates a finished zone from the next zone's load. `done` is high for exactly that one cycle after the last zone, and `busy` drops on the following cycle.
- R8: A `start` pulse while `busy` is high has no effect on the write sequence or on the results.
- R9: `cal_value` and `cal_err` show, without a clock delay, the stored entry of the zone selected by `rd_zone`. Each entry holds until a later run overwrites it.
- R10: After reset, `busy`, `done` and `wr_en` are 0, and every table entry reads value 0 with error bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run (used only when idle) |
| nominal | input | DACW | Starting DAC code for each zone |
| settle_len | input | SETTLEW | Settling wait after each DAC write, minus one |
| num_tbl | input | NZONES*RATEW | Per-zone rate numerators, zone z in slice z |
| den_tbl | input | NZONES*RATEW | Per-zone rate denominators, zone z in slice z |
| cmp_above | input | 1 | Comparator flag: control voltage above midpoint |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last zone |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register write address (0 when idle) |
| wr_data | output | max(DACW,RATEW) | Register write data (0 when idle) |
| rd_zone | input | ZW | Zone index for the table readout |
| cal_value | output | DACW | Calibrated DAC code of the selected zone |
| cal_err | output | 1 | Selected zone ended at a code limit |

## Verification
The assertions assume that `cmp_above` stays stable for the whole settling window that ends in a sample. They also assume that `nominal`, `settle_len` and the rate tables do not change while `busy` is high. The bench's comparator model changes the flag only on the negative edge at which it sees a new DAC write. It then keeps the flag at the comparison of that code with the zone's threshold, and all configuration inputs are set only while the block is idle. The thresholds are chosen so that one run exercises a downward search, an upward search and saturation at both ends.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_NUM    = 3'd1,
      S_DEN    = 3'd2,
      S_DAC    = 3'd3,
      S_SETTLE = 3'd4,
      S_NEXT   = 3'd5
   } cal_state_e;

   localparam logic [7:0] ADDR_NUM = 8'h0E;
   localparam logic [7:0] ADDR_DEN = 8'h06;
   localparam logic [7:0] ADDR_DAC = 8'h04;

endpackage

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
   parameter int SETTLEW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [SETTLEW-1:0] len,
   output logic               expired
);

   logic [SETTLEW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= len;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // a freshly loaded window is already over only when its length is zero
   assert_settle_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (expired == ($past(len) == '0)));

endmodule

// File: rtl/osc_cal_table.sv
module osc_cal_table #(
   parameter int NZONES = 4,
   parameter int DACW   = 8,
   parameter int ZW     = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [ZW-1:0]   wzone,
   input  logic [DACW-1:0] wvalue,
   input  logic            werr,
   input  logic [ZW-1:0]   rzone,
   output logic [DACW-1:0] rvalue,
   output logic            rerr
);

   logic [DACW-1:0] val_q [NZONES];
   logic            err_q [NZONES];

   for (genvar i = 0; i < NZONES; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q[i] <= '0;
            err_q[i] <= 1'b0;
         end else if (we && wzone == ZW'(i)) begin
            val_q[i] <= wvalue;
            err_q[i] <= werr;
         end
      end

      assert_entry_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (we && wzone == ZW'(i)) |=> (val_q[i] == $past(wvalue) && err_q[i] == $past(werr)));
   end

   always_comb begin
      if (int'(rzone) < NZONES) begin
         rvalue = val_q[rzone];
         rerr   = err_q[rzone];
      end else begin
         rvalue = '0;
         rerr   = 1'b0;
      end
   end

endmodule

// File: rtl/osc_cal_seq.sv
module osc_cal_seq
   import osc_cal_pkg::*;
#(
   parameter int NZONES  = 4,
   parameter int DACW    = 8,
   parameter int RATEW   = 8,
   parameter int SETTLEW = 8,
   localparam int ZW     = (NZONES > 1) ? $clog2(NZONES) : 1,
   localparam int DATAW  = (DACW > RATEW) ? DACW : RATEW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [DACW-1:0]         nominal,
   input  logic [SETTLEW-1:0]      settle_len,
   input  logic [NZONES*RATEW-1:0] num_tbl,
   input  logic [NZONES*RATEW-1:0] den_tbl,
   input  logic                    cmp_above,
   output logic                    busy,
   output logic                    done,
   output logic                    wr_en,
   output logic [7:0]              wr_addr,
   output logic [DATAW-1:0]        wr_data,
   input  logic [ZW-1:0]           rd_zone,
   output logic [DACW-1:0]         cal_value,
   output logic                    cal_err
);

   localparam logic [DACW-1:0] DAC_MAX   = '1;
   localparam logic [ZW-1:0]   LAST_ZONE = ZW'(NZONES - 1);

   if (NZONES < 1) begin : g_chk_zones
      $error("NZONES must be at least 1");
   end
   if (DACW < 2) begin : g_chk_dacw
      $error("DACW must be at least 2");
   end
   if (RATEW < 1 || SETTLEW < 1) begin : g_chk_widths
      $error("RATEW and SETTLEW must be at least 1");
   end

   cal_state_e       st_q, st_d;
   logic [ZW-1:0]    zone_q;
   logic [DACW-1:0]  dac_q;
   logic             ref_q, have_ref_q;
   logic             tmr_load, tmr_expired;
   logic             sample, reversed, at_limit, finish_zone, do_step;
   logic [RATEW-1:0] num_sel, den_sel;

   // rate slice of the active zone
   if (NZONES == 1) begin : g_one_zone
      assign num_sel = num_tbl[RATEW-1:0];
      assign den_sel = den_tbl[RATEW-1:0];
   end else begin : g_many_zones
      assign num_sel = num_tbl[zone_q*RATEW +: RATEW];
      assign den_sel = den_tbl[zone_q*RATEW +: RATEW];
   end

   assign sample      = (st_q == S_SETTLE) && tmr_expired;
   assign reversed    = have_ref_q && (cmp_above != ref_q);
   assign at_limit    = cmp_above ? (dac_q == '0) : (dac_q == DAC_MAX);
   assign finish_zone = sample && (reversed || at_limit);
   assign do_step     = sample && !finish_zone;
   assign tmr_load    = (st_q == S_DAC);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:   if (start) st_d = S_NUM;
         S_NUM:    st_d = S_DEN;
         S_DEN:    st_d = S_DAC;
         S_DAC:    st_d = S_SETTLE;
         S_SETTLE: if (finish_zone) st_d = S_NEXT;
                   else if (do_step) st_d = S_DAC;
         S_NEXT:   st_d = (zone_q == LAST_ZONE) ? S_IDLE : S_NUM;
         default:  st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         zone_q     <= '0;
         dac_q      <= '0;
         ref_q      <= 1'b0;
         have_ref_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == S_IDLE && start)
            zone_q <= '0;
         else if (st_q == S_NEXT && zone_q != LAST_ZONE)
            zone_q <= zone_q + 1'b1;
         if (st_q == S_NUM)
            have_ref_q <= 1'b0;
         else if (sample) begin
            have_ref_q <= 1'b1;
            ref_q      <= cmp_above;
         end
         if (st_q == S_DEN)
            dac_q <= nominal;
         else if (do_step)
            dac_q <= cmp_above ? dac_q - 1'b1 : dac_q + 1'b1;
      end
   end

   assign busy  = (st_q != S_IDLE);
   assign done  = (st_q == S_NEXT) && (zone_q == LAST_ZONE);
   assign wr_en = (st_q == S_NUM) || (st_q == S_DEN) || (st_q == S_DAC);

   always_comb begin
      wr_addr = '0;
      wr_data = '0;
      unique case (st_q)
         S_NUM: begin wr_addr = ADDR_NUM; wr_data = DATAW'(num_sel); end
         S_DEN: begin wr_addr = ADDR_DEN; wr_data = DATAW'(den_sel); end
         S_DAC: begin wr_addr = ADDR_DAC; wr_data = DATAW'(dac_q);   end
         default: ;
      endcase
   end

   osc_settle_timer #(.SETTLEW(SETTLEW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .len     (settle_len),
      .expired (tmr_expired)
   );

   osc_cal_table #(.NZONES(NZONES), .DACW(DACW), .ZW(ZW)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (finish_zone),
      .wzone  (zone_q),
      .wvalue (dac_q),
      .werr   (!reversed),
      .rzone  (rd_zone),
      .rvalue (cal_value),
      .rerr   (cal_err)
   );

   assert_addr_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr == ADDR_NUM || wr_addr == ADDR_DEN || wr_addr == ADDR_DAC));

   assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_step |=> (dac_q == DACW'($past(dac_q) + 1'b1) || dac_q == DACW'($past(dac_q) - 1'b1)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);

endmodule

// File: tb/osc_cal_seq_bench.sv
module osc_cal_seq_bench;

   localparam int NZ = 4;

   typedef struct {
      bit         busy;
      bit         we;
      logic [7:0] addr;
      logic [7:0] data;
      bit         done;
      string      tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [7:0]      nominal = 8'd0;
   logic [7:0]      settle_len = 8'd0;
   logic [NZ*8-1:0] num_tbl = 32'h44332211;
   logic [NZ*8-1:0] den_tbl = 32'hD4C3B2A1;
   logic            cmp_above = 1'b0;
   logic            busy, done, wr_en, cal_err;
   logic [7:0]      wr_addr, wr_data, cal_value;
   logic [1:0]      rd_zone = 2'd0;

   int   checks = 0;
   int   failures = 0;
   int   thr [NZ];
   int   exp_val [NZ];
   bit   exp_err [NZ];
   exp_t q [$];
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   osc_cal_seq u_osc_cal_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .nominal(nominal),
      .settle_len(settle_len), .num_tbl(num_tbl), .den_tbl(den_tbl),
      .cmp_above(cmp_above), .busy(busy), .done(done), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_zone(rd_zone),
      .cal_value(cal_value), .cal_err(cal_err)
   );

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic push(bit b, bit w, logic [7:0] a, logic [7:0] d, bit dn, string t);
      exp_t e;
      e.busy = b; e.we = w; e.addr = a; e.data = d; e.done = dn; e.tag = t;
      q.push_back(e);
   endtask

   // behavioural prediction of the whole run
   task automatic build(int settle, int nom);
      for (int z = 0; z < NZ; z++) begin
         int v = nom;
         bit have = 0;
         bit prev = 0;
         push(1, 1, 8'h0E, num_tbl[z*8 +: 8], 0, "R1");
         push(1, 1, 8'h06, den_tbl[z*8 +: 8], 0, "R1");
         push(1, 1, 8'h04, 8'(v), 0, "R2");
         forever begin
            bit f;
            for (int s = 0; s <= settle; s++) push(1, 0, 8'h00, 8'h00, 0, "R3");
            f = (v > thr[z]);
            if (have && f != prev) begin
               exp_val[z] = v; exp_err[z] = 0; break;
            end
            if ((f && v == 0) || (!f && v == 255)) begin
               exp_val[z] = v; exp_err[z] = 1; break;
            end
            have = 1; prev = f;
            v = f ? v - 1 : v + 1;
            push(1, 1, 8'h04, 8'(v), 0, "R4");
         end
         push(1, 0, 8'h00, 8'h00, (z == NZ - 1), "R7");
      end
      push(0, 0, 8'h00, 8'h00, 0, "R7");
   endtask

   task automatic run(int settle, int nom, int poke_at);
      int zi = -1;
      int dacm = 0;
      int n = 0;
      @(negedge clk);
      settle_len = 8'(settle);
      nominal = 8'(nom);
      cmp_above = 1'b0;
      build(settle, nom);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (q.size() > 0) begin
         exp_t e = q.pop_front();
         string t = (n == poke_at + 1) ? "R8" : e.tag;
         logic [18:0] a = {busy, wr_en, wr_addr, wr_data, done};
         logic [18:0] x = {e.busy, e.we, e.addr, e.data, e.done};
         check(a == x, t, 32'(a), 32'(x));
         if (wr_en && wr_addr == 8'h0E) zi++;
         if (wr_en && wr_addr == 8'h04) dacm = int'(wr_data);
         if (zi >= 0 && zi < NZ) cmp_above = (dacm > thr[zi]);
         start = (n == poke_at);
         n++;
         @(negedge clk);
      end
      start = 1'b0;
      for (int z = 0; z < NZ; z++) begin
         rd_zone = 2'(z);
         #1;
         check(cal_value == 8'(exp_val[z]) && cal_err == exp_err[z],
               exp_err[z] ? "R6" : "R5",
               {23'd0, cal_err, cal_value}, {23'd0, exp_err[z], 8'(exp_val[z])});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, wr_en} == 3'b000, "R10", {29'd0, busy, done, wr_en}, 32'd0);
      for (int z = 0; z < NZ; z++) begin
         rd_zone = 2'(z);
         #1;
         check({cal_err, cal_value} == 9'd0, "R10", {23'd0, cal_err, cal_value}, 32'd0);
      end
      rst_n = 1'b1;
      // downward, upward, floor saturation, ceiling saturation
      thr = '{100, 140, -1, 255};
      run(3, 128, 20);
      // persistence: results hold while idle and are read again (R9)
      repeat (5) @(negedge clk);
      for (int z = 0; z < NZ; z++) begin
         rd_zone = 2'(z);
         #1;
         check(cal_value == 8'(exp_val[z]) && cal_err == exp_err[z], "R9",
               {23'd0, cal_err, cal_value}, {23'd0, exp_err[z], 8'(exp_val[z])});
      end
      // zero settle, other nominal, fresh rates
      num_tbl = 32'h0F1E2D3C;
      den_tbl = 32'h5A6B7C8D;
      thr = '{199, 230, 255, 10};
      run(0, 200, 7);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule